// File: doc/BRIEF.md
# Capture/Reload Timer with Baud-Clock Mode

This block is a 16-bit up-counter for a small microcontroller subsystem. It advances on an input tick while its run bit is set. It can work in one of three ways. In capture mode it latches its count when an external pin falls. In auto-reload mode it restarts from a programmed value on overflow or on that pin edge. In baud-clock mode it acts as a rate generator for a serial port's transmit and receive sides.

Software reaches four 16-bit locations through a simple write/address port with combinational read data. Address 0 is control and status, 1 is the count, 2 is the reload value and 3 is the capture value. Two sticky flags report an overflow and an external-pin event, and their OR drives an interrupt request. Two selector bits pick, for transmit and receive independently, whether the serial baud pulse comes from this timer's overflow or from another timer's overflow input.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset, the control word reads 0, the count, reload and capture values read 0, both flags and `irq` are low, and each baud output follows `other_ovf`.
- R2: The count increments by one on each cycle with `tick` high while run (control bit 0) is set. It holds when `tick` is low or run is clear.
- R3: In capture mode (control bit 1 = 1), an overflow from 0xFFFF wraps the count to 0 and sets the overflow flag (control bit 6).
- R4: In auto-reload mode (control bit 1 = 0), an overflow loads the count from the reload register and sets the overflow flag.
- R5: `ext_pin` passes through two synchronising flops. A sampled 1 followed by a sampled 0 is a falling edge, and it acts on the third rising clock edge after the pin goes low. In capture mode with ext-enable (control bit 2) set, it copies the count into the capture register and sets the external flag (control bit 7).
- R6: In auto-reload mode with ext-enable set, a falling edge on `ext_pin` loads the count from the reload register and sets the external flag.
- R7: With ext-enable clear, falling edges on `ext_pin` change neither the capture register, the count nor the external flag.
- R8: When either baud selector (control bit 3 transmit, bit 4 receive) is set, `ext_pin` edges are ignored. An overflow reloads the count from the reload register and does not set the overflow flag.
- R9: `tx_baud` equals this timer's overflow pulse (`tick` high with run set and count 0xFFFF) when bit 3 is set, and `other_ovf` otherwise. `rx_baud` does the same with bit 4.
- R10: Both flags stay set until a control write stores 0 in them. `irq` is their OR.
- R11: Writes to address 3 (capture) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 control, 1 count, 2 reload, 3 capture |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| tick | input | 1 | Count enable pulse |
| ext_pin | input | 1 | Asynchronous external trigger pin |
| other_ovf | input | 1 | Overflow pulse from the other timer |
| tx_baud | output | 1 | Transmit baud pulse |
| rx_baud | output | 1 | Receive baud pulse |
| irq | output | 1 | OR of overflow and external flags |

## Verification
A corrupted count, reload or capture register becomes visible the moment it is read back, and at the next overflow, when the reloaded value or the wrap lands in the count. A wrong synchroniser state moves the capture or reload by a whole cycle, so the bench samples exactly two and three edges after the pin falls. A wrong flag or mode bit shows on `irq` and the baud outputs in the same cycle the event occurs.

// File: rtl/cap_reload_timer.sv
module cap_reload_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic         tick,
  input  logic         ext_pin,
  input  logic         other_ovf,
  output logic         tx_baud,
  output logic         rx_baud,
  output logic         irq
);
  logic [W-1:0] count, reload, capture;
  logic run, cap_mode, ext_en, tx_sel, rx_sel, ovf_flag, ext_flag;
  logic [2:0] sync;

  wire baud   = tx_sel | rx_sel;
  wire ovf    = run & tick & (&count);
  wire fall   = sync[2] & ~sync[1];
  wire trig   = fall & ext_en & ~baud;
  wire wr_ctl = wr && addr == 2'd0;

  assign tx_baud = tx_sel ? ovf : other_ovf;
  assign rx_baud = rx_sel ? ovf : other_ovf;
  assign irq     = ovf_flag | ext_flag;

  always_ff @(posedge clk) begin
    if (!rst_n) sync <= 3'b111;
    else        sync <= {sync[1:0], ext_pin};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {run, cap_mode, ext_en, tx_sel, rx_sel} <= '0;
      ovf_flag <= 1'b0;
      ext_flag <= 1'b0;
    end else begin
      if (wr_ctl) {rx_sel, tx_sel, ext_en, cap_mode, run} <= wdata[4:0];
      ovf_flag <= (wr_ctl ? wdata[6] : ovf_flag) | (ovf & ~baud);
      ext_flag <= (wr_ctl ? wdata[7] : ext_flag) | trig;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      reload  <= '0;
      capture <= '0;
    end else begin
      if (wr && addr == 2'd1)
        count <= wdata;
      else if ((ovf && (baud || !cap_mode)) || (trig && !cap_mode))
        count <= reload;
      else if (run && tick)
        count <= count + 1'b1;
      if (wr && addr == 2'd2) reload <= wdata;
      if (trig && cap_mode)   capture <= count;
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = W'({ext_flag, ovf_flag, 1'b0, rx_sel, tx_sel, ext_en, cap_mode, run});
      2'd1:    rdata = count;
      2'd2:    rdata = reload;
      default: rdata = capture;
    endcase
  end

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_flag) || $fell(ext_flag) |-> $past(wr_ctl));

  assert_baud_no_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && baud && !wr_ctl) |=> $stable(ovf_flag));

  assert_ext_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_flag) |-> $past(wr_ctl) || ($past(ext_en) && !$past(baud)));

  assert_reload_on_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !cap_mode && !(wr && addr == 2'd1)) |=> count == $past(reload));
endmodule

// File: tb/cap_reload_timer_test.sv
`timescale 1ns/1ps
module cap_reload_timer_test;
  logic clk = 1'b0, rst_n = 1'b0, wr = 1'b0, tick = 1'b0, ext_pin = 1'b1, other_ovf = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [15:0] wdata = '0, rdata;
  logic tx_baud, rx_baud, irq;
  int vecs = 0, bad = 0;
  bit done = 0;

  cap_reload_timer #(.W(16)) uut (.clk(clk), .rst_n(rst_n), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tick(tick), .ext_pin(ext_pin), .other_ovf(other_ovf),
    .tx_baud(tx_baud), .rx_baud(rx_baud), .irq(irq));

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    vecs++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [15:0] v);
    addr = a; #0.5 v = rdata;
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic drop_pin(input int wait_n);
    @(negedge clk); ext_pin = 1'b0;
    repeat (wait_n) @(negedge clk);
  endtask

  task automatic raise_pin();
    ext_pin = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int a = 0; a < 4; a++) begin rreg(a[1:0], v); chk("R1", v, 16'h0); end
    chk("R1 irq", {15'b0, irq}, 16'h0);
    other_ovf = 1'b1; #0.5;
    chk("R1 baud", {14'b0, tx_baud, rx_baud}, 16'h3);
    other_ovf = 1'b0;
  endtask

  task automatic t_count();
    logic [15:0] v;
    wreg(2'd0, 16'h0001); wreg(2'd1, 16'd10);
    run_ticks(5);
    rreg(2'd1, v); chk("R2 count", v, 16'd15);
    repeat (3) @(negedge clk);
    rreg(2'd1, v); chk("R2 hold no tick", v, 16'd15);
    wreg(2'd0, 16'h0000); run_ticks(4);
    rreg(2'd1, v); chk("R2 hold no run", v, 16'd15);
  endtask

  task automatic t_reload_ovf();
    logic [15:0] v;
    wreg(2'd2, 16'h1234); wreg(2'd1, 16'hFFFE); wreg(2'd0, 16'h0001);
    run_ticks(2);
    rreg(2'd1, v); chk("R4 reload", v, 16'h1234);
    rreg(2'd0, v); chk("R4 flag", v & 16'h40, 16'h40);
    repeat (3) @(negedge clk);
    chk("R10 sticky irq", {15'b0, irq}, 16'h1);
    wreg(2'd0, 16'h0000);
    rreg(2'd0, v); chk("R10 clear", v, 16'h0);
    chk("R10 irq low", {15'b0, irq}, 16'h0);
  endtask

  task automatic t_cap_ovf();
    logic [15:0] v;
    wreg(2'd1, 16'hFFFF); wreg(2'd0, 16'h0003);
    run_ticks(1);
    rreg(2'd1, v); chk("R3 wrap", v, 16'h0000);
    rreg(2'd0, v); chk("R3 flag", v & 16'h40, 16'h40);
    wreg(2'd0, 16'h0000);
  endtask

  task automatic t_capture();
    logic [15:0] v;
    wreg(2'd1, 16'h0ABC); wreg(2'd0, 16'h0006);
    drop_pin(2);
    rreg(2'd3, v); chk("R5 not yet at edge 2", v, 16'h0000);
    @(negedge clk);
    rreg(2'd3, v); chk("R5 capture", v, 16'h0ABC);
    rreg(2'd0, v); chk("R5 ext flag", v & 16'h80, 16'h80);
    raise_pin();
    wreg(2'd0, 16'h0000);
  endtask

  task automatic t_ext_reload();
    logic [15:0] v;
    wreg(2'd2, 16'h5555); wreg(2'd1, 16'h0100); wreg(2'd0, 16'h0004);
    drop_pin(3);
    rreg(2'd1, v); chk("R6 reload", v, 16'h5555);
    rreg(2'd0, v); chk("R6 ext flag", v & 16'h80, 16'h80);
    raise_pin();
    wreg(2'd0, 16'h0000);
  endtask

  task automatic t_ext_disabled();
    logic [15:0] v;
    wreg(2'd1, 16'h0777); wreg(2'd0, 16'h0002);
    drop_pin(4);
    rreg(2'd3, v); chk("R7 capture kept", v, 16'h0ABC);
    rreg(2'd0, v); chk("R7 no flag", v, 16'h0002);
    raise_pin();
    wreg(2'd0, 16'h0000);
    wreg(2'd1, 16'h0777); wreg(2'd0, 16'h0000);
    drop_pin(4);
    rreg(2'd1, v); chk("R7 count kept", v, 16'h0777);
    raise_pin();
  endtask

  task automatic t_baud();
    logic [15:0] v;
    wreg(2'd2, 16'hFFF0); wreg(2'd1, 16'hFFFF); wreg(2'd0, 16'h000D);
    @(negedge clk); tick = 1'b1; #0.5;
    chk("R9 tx from own ovf", {15'b0, tx_baud}, 16'h1);
    chk("R9 rx from other", {15'b0, rx_baud}, 16'h0);
    @(negedge clk); tick = 1'b0;
    rreg(2'd1, v); chk("R8 baud reload", v, 16'hFFF0);
    rreg(2'd0, v); chk("R8 no ovf flag", v, 16'h000D);
    drop_pin(4);
    rreg(2'd1, v); chk("R8 ext ignored count", v, 16'hFFF0);
    chk("R8 ext ignored irq", {15'b0, irq}, 16'h0);
    raise_pin();
    wreg(2'd0, 16'h0010);
    other_ovf = 1'b1; #0.5;
    chk("R9 tx from other", {15'b0, tx_baud}, 16'h1);
    chk("R9 rx own idle", {15'b0, rx_baud}, 16'h0);
    other_ovf = 1'b0;
    wreg(2'd0, 16'h0000);
  endtask

  task automatic t_capwrite();
    logic [15:0] v;
    wreg(2'd3, 16'hDEAD);
    rreg(2'd3, v); chk("R11 capture write ignored", v, 16'h0ABC);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_reload_ovf();
    t_cap_ovf();
    t_capture();
    t_ext_reload();
    t_ext_disabled();
    t_baud();
    t_capwrite();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        vecs++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule